// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block collects a set of level-sensitive request lines from on-chip peripherals and presents one interrupt line to the host processor. Each source can be enabled on its own through a mask register. A global enable gates the output. One chosen source can be promoted above the others. Otherwise a fixed order applies: the lowest-numbered source is the most urgent. An in-service register records which sources the host is handling. A source that is in service holds back every source of equal or lower urgency until the host clears its bit.

The host reads a vector in two steps. It first writes the vector register with the acknowledge bit set, then reads that register. The read returns the winning source number. On acknowledge, the winner's in-service bit is set. If no source is eligible at the moment of acknowledge, the register holds an error vector instead and no in-service bit changes. This happens when the request that raised the line has gone away or was masked in the meantime. To end an interrupt, the host writes a one to the source's in-service bit. Because requests are levels, a source that is still asserted requests again once it is cleared.

A small register port reaches five registers: configuration at address 0, mask at 1, pending at 2, in-service at 3 and vector at 4. Reads are combinational. Writes take effect at the clock edge.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, the configuration, mask, in-service and vector registers read zero, `irqOut` is low and `irqLevel` is zero.
- R2: Mask bit n at address 1 enables source n when set. A source whose mask bit is clear never causes `irqOut` to assert.
- R3: While configuration bit 0 (global enable) is clear, `irqOut` stays low, whatever the requests and mask.
- R4: When no source is promoted, an acknowledge selects the lowest-numbered source that is pending and enabled. A read of address 4 returns that number in its low bits and zero in every higher bit.
- R5: When configuration bit 1 is set, the source numbered by the index field at configuration bits 2 and up wins over all others whenever it is pending and enabled.
- R6: An acknowledge sets the winner's in-service bit. `irqOut` then falls and stays low until a strictly more urgent source becomes eligible, which raises it again (nesting).
- R7: Writing address 3 clears each in-service bit written as 1. Bits written as 0 keep their value.
- R8: A source that is still requesting when its in-service bit is cleared raises `irqOut` again.
- R9: An acknowledge with no eligible source loads the error vector (the value equal to the number of sources) and leaves the in-service register unchanged. This covers a request that was removed and a source that was masked after `irqOut` rose.
- R10: The 3-bit request-level field at configuration bits 15:13 drives `irqLevel` and reads back, together with the enable, promote and index fields.
- R11: Address 2 returns the request lines as sampled one clock earlier.
- R12: `irqOut` is registered. It reflects the eligibility computed from the state one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | NUM_SRC | Level request lines, bit n is source n |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| irqOut | output | 1 | Interrupt request to the host |
| irqLevel | output | 3 | Request-level field from the configuration register |

## Verification
The assertions assume that at most one register write arrives per cycle. They also assume that `reqIn` changes only between clock edges, so each sampled request is held for a whole cycle. The bench drives every input on the falling edge and issues writes one at a time through a task, so both conditions always hold. The race cases (a request withdrawn or masked after `irqOut` rose) are built by allowing at least one full cycle between the change and the acknowledge, so the bench expects the error vector with no ambiguity.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;

  localparam int REG_ADDR_W    = 3;
  localparam int EN_BIT        = 0;
  localparam int PROMO_EN_BIT  = 1;
  localparam int PROMO_IDX_LSB = 2;
  localparam int LEVEL_LSB     = 13;
  localparam int LEVEL_W       = 3;
  localparam int ACK_BIT       = 0;

  typedef enum logic [2:0] {
    SEL_CFG  = 3'd0,
    SEL_MASK = 3'd1,
    SEL_PEND = 3'd2,
    SEL_SVC  = 3'd3,
    SEL_VEC  = 3'd4,
    SEL_NONE = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    cfgWr;
    logic    maskWr;
    logic    svcClr;
    logic    ack;
    regSel_e rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/vec_irq_prio.sv
// Picks the most urgent set bit of a vector: a promoted index first,
// otherwise the lowest index. Rank 0 is the most urgent.
module vec_irq_prio #(
  parameter int NUM_SRC = 32,
  parameter int SRC_W   = 5,
  parameter int RANK_W  = 6
) (
  input  logic [NUM_SRC-1:0] reqVec,
  input  logic               promoEn,
  input  logic [SRC_W-1:0]   promoIdx,
  output logic               hit,
  output logic [SRC_W-1:0]   winIdx,
  output logic [RANK_W-1:0]  winRank
);

  logic promoHit;

  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (reqVec[i]) winIdx = SRC_W'(i);
    end
    promoHit = promoEn && (int'(promoIdx) < NUM_SRC) && reqVec[promoIdx];
    if (promoHit) winIdx = promoIdx;
    hit = |reqVec;
    if (promoHit) winRank = '0;
    else          winRank = RANK_W'(winIdx) + RANK_W'(1);
  end

endmodule

// File: rtl/vec_irq_decode.sv
// Register-port control: turns the write port into datapath strobes.
module vec_irq_decode
  import vec_irq_pkg::*;
(
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  ackBit,
  output ctlStrobe_t            ctlStb
);

  always_comb begin
    ctlStb        = '0;
    ctlStb.rdSel  = SEL_NONE;
    case (regAddr)
      3'd0: ctlStb.rdSel = SEL_CFG;
      3'd1: ctlStb.rdSel = SEL_MASK;
      3'd2: ctlStb.rdSel = SEL_PEND;
      3'd3: ctlStb.rdSel = SEL_SVC;
      3'd4: ctlStb.rdSel = SEL_VEC;
      default: ctlStb.rdSel = SEL_NONE;
    endcase
    if (regWrEn) begin
      ctlStb.cfgWr  = (ctlStb.rdSel == SEL_CFG);
      ctlStb.maskWr = (ctlStb.rdSel == SEL_MASK);
      ctlStb.svcClr = (ctlStb.rdSel == SEL_SVC);
      ctlStb.ack    = (ctlStb.rdSel == SEL_VEC) && ackBit;
    end
  end

endmodule

// File: rtl/vec_irq_dp.sv
// Register state, eligibility and arbitration.
module vec_irq_dp
  import vec_irq_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  reqIn,
  input  logic [31:0]         wrData,
  input  ctlStrobe_t          ctlStb,
  output logic [31:0]         rdData,
  output logic                irqOut,
  output logic [LEVEL_W-1:0]  irqLevel,
  output logic [NUM_SRC-1:0]  svcState,
  output logic [NUM_SRC-1:0]  maskState,
  output logic [NUM_SRC-1:0]  pendState,
  output logic                cfgEnState
);

  localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int VEC_W   = $clog2(NUM_SRC + 1);
  localparam int RANK_W  = VEC_W;
  localparam logic [VEC_W-1:0] ERR_VEC = VEC_W'(NUM_SRC);

  logic                 cfgEn;
  logic                 promoEn;
  logic [SRC_W-1:0]     promoIdx;
  logic [LEVEL_W-1:0]   levelReg;
  logic [NUM_SRC-1:0]   maskReg;
  logic [NUM_SRC-1:0]   pendReg;
  logic [NUM_SRC-1:0]   svcReg;
  logic [VEC_W-1:0]     vecReg;
  logic                 irqReg;

  logic [NUM_SRC-1:0]   eligible;
  logic                 eligHit, svcHit, candValid;
  logic [SRC_W-1:0]     eligIdx, svcIdx;
  logic [RANK_W-1:0]    eligRank, svcRank;
  logic [NUM_SRC-1:0]   svcNext;
  logic                 unusedSvcIdx;
  logic                 unusedWrBits;

  assign unusedSvcIdx = ^svcIdx;
  assign unusedWrBits = ^wrData;
  assign eligible     = pendReg & maskReg;

  vec_irq_prio #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .RANK_W(RANK_W)) u_eligPrio (
    .reqVec(eligible), .promoEn(promoEn), .promoIdx(promoIdx),
    .hit(eligHit), .winIdx(eligIdx), .winRank(eligRank)
  );

  vec_irq_prio #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .RANK_W(RANK_W)) u_svcPrio (
    .reqVec(svcReg), .promoEn(promoEn), .promoIdx(promoIdx),
    .hit(svcHit), .winIdx(svcIdx), .winRank(svcRank)
  );

  // A candidate must be strictly more urgent than anything in service.
  assign candValid = eligHit && (!svcHit || (eligRank < svcRank));

  always_comb begin
    svcNext = svcReg;
    if (ctlStb.svcClr) svcNext = svcNext & ~wrData[NUM_SRC-1:0];
    if (ctlStb.ack && candValid) svcNext = svcNext | (NUM_SRC'(1) << eligIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgEn    <= 1'b0;
      promoEn  <= 1'b0;
      promoIdx <= '0;
      levelReg <= '0;
      maskReg  <= '0;
      pendReg  <= '0;
      svcReg   <= '0;
      vecReg   <= '0;
      irqReg   <= 1'b0;
    end else begin
      pendReg <= reqIn;
      svcReg  <= svcNext;
      irqReg  <= cfgEn && candValid;
      if (ctlStb.cfgWr) begin
        cfgEn    <= wrData[EN_BIT];
        promoEn  <= wrData[PROMO_EN_BIT];
        promoIdx <= wrData[PROMO_IDX_LSB +: SRC_W];
        levelReg <= wrData[LEVEL_LSB +: LEVEL_W];
      end
      if (ctlStb.maskWr) maskReg <= wrData[NUM_SRC-1:0];
      if (ctlStb.ack) vecReg <= candValid ? VEC_W'(eligIdx) : ERR_VEC;
    end
  end

  always_comb begin
    rdData = '0;
    case (ctlStb.rdSel)
      SEL_CFG: begin
        rdData[EN_BIT]                  = cfgEn;
        rdData[PROMO_EN_BIT]            = promoEn;
        rdData[PROMO_IDX_LSB +: SRC_W]  = promoIdx;
        rdData[LEVEL_LSB +: LEVEL_W]    = levelReg;
      end
      SEL_MASK: rdData = 32'(maskReg);
      SEL_PEND: rdData = 32'(pendReg);
      SEL_SVC:  rdData = 32'(svcReg);
      SEL_VEC:  rdData = 32'(vecReg);
      default:  rdData = '0;
    endcase
  end

  assign irqOut     = irqReg;
  assign irqLevel   = levelReg;
  assign svcState   = svcReg;
  assign maskState  = maskReg;
  assign pendState  = pendReg;
  assign cfgEnState = cfgEn;

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_SRC-1:0]     reqIn,
  input  logic                   regWrEn,
  input  logic [REG_ADDR_W-1:0]  regAddr,
  input  logic [31:0]            regWrData,
  output logic [31:0]            regRdData,
  output logic                   irqOut,
  output logic [LEVEL_W-1:0]     irqLevel
);

  ctlStrobe_t          ctlStb;
  logic [NUM_SRC-1:0]  svcState;
  logic [NUM_SRC-1:0]  maskState;
  logic [NUM_SRC-1:0]  pendState;
  logic                cfgEnState;

  vec_irq_decode u_decode (
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .ackBit(regWrData[ACK_BIT]),
    .ctlStb(ctlStb)
  );

  vec_irq_dp #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .reqIn(reqIn),
    .wrData(regWrData),
    .ctlStb(ctlStb),
    .rdData(regRdData),
    .irqOut(irqOut),
    .irqLevel(irqLevel),
    .svcState(svcState),
    .maskState(maskState),
    .pendState(pendState),
    .cfgEnState(cfgEnState)
  );

endmodule

// File: rtl/vec_irq_chk.sv
module vec_irq_chk #(
  parameter int NUM_SRC = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [2:0]         regAddr,
  input logic [31:0]        regWrData,
  input logic [31:0]        regRdData,
  input logic               irqOut,
  input logic [2:0]         irqLevel,
  input logic [NUM_SRC-1:0] svcState,
  input logic [NUM_SRC-1:0] maskState,
  input logic [NUM_SRC-1:0] pendState,
  input logic               cfgEnState
);

  localparam int VEC_W = $clog2(NUM_SRC + 1);

  logic ackWr, svcWr, cfgWr;
  assign ackWr = regWrEn && (regAddr == 3'd4) && regWrData[0];
  assign svcWr = regWrEn && (regAddr == 3'd3);
  assign cfgWr = regWrEn && (regAddr == 3'd0);

  // R3
  en_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnState |=> !irqOut);

  // R2
  irq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(|(pendState & maskState)));

  // R6
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackWr |=> ($countones(svcState ^ $past(svcState)) <= 1));

  // R7
  svc_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (svcWr && (regWrData[NUM_SRC-1:0] == '1)) |=> (svcState == '0));

  // R10
  level_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWr |=> $stable(irqLevel));

  // R4
  vec_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd4) |-> ((regRdData >> VEC_W) == 32'd0));

endmodule

bind vec_irq_ctrl vec_irq_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .regWrEn(regWrEn),
  .regAddr(regAddr),
  .regWrData(regWrData),
  .regRdData(regRdData),
  .irqOut(irqOut),
  .irqLevel(irqLevel),
  .svcState(svcState),
  .maskState(maskState),
  .pendState(pendState),
  .cfgEnState(cfgEnState)
);

// File: tb/vec_irq_ctrl_tb.sv
module vec_irq_ctrl_tb;

  localparam int NS  = 8;
  localparam int ERR = NS;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] reqIn = '0;
  logic          regWrEn = 1'b0;
  logic [2:0]    regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic          irqOut;
  logic [2:0]    irqLevel;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  vec_irq_ctrl #(.NUM_SRC(NS)) u_dut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut), .irqLevel(irqLevel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] cfgVal(input bit en, input bit pe, input int idx, input int lvl);
    return 32'(en) | (32'(pe) << 1) | (32'(idx) << 2) | (32'(lvl) << 13);
  endfunction

  function automatic int lowest(input logic [NS-1:0] p);
    for (int i = NS - 1; i >= 0; i--) if (p[i]) lowest = i;
  endfunction

  task automatic ackRead(output logic [31:0] v);
    wr(3'd4, 32'h1);
    rd(3'd4, v);
  endtask

  task automatic cleanup();
    reqIn = '0;
    wr(3'd3, 32'hFF);
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irqOut", 32'(irqOut), 0);
    chk("R1 irqLevel", 32'(irqLevel), 0);
    rd(3'd0, v); chk("R1 cfg", v, 0);
    rd(3'd1, v); chk("R1 mask", v, 0);
    rd(3'd3, v); chk("R1 svc", v, 0);
    rd(3'd4, v); chk("R1 vec", v, 0);

    // R11 pending mirrors requests
    reqIn = 8'hA5; settle();
    rd(3'd2, v); chk("R11 pend", v, 32'hA5);
    reqIn = 8'h3C; @(negedge clk); @(negedge clk);
    rd(3'd2, v); chk("R11 pend2", v, 32'h3C);

    // R2 masked sources stay silent
    wr(3'd0, cfgVal(1, 0, 0, 0));
    reqIn = 8'hFF; settle();
    chk("R2 all masked", 32'(irqOut), 0);
    for (int n = 0; n < NS; n++) begin
      reqIn = 8'(1 << n);
      wr(3'd1, 32'(~(1 << n)) & 32'hFF); settle();
      chk("R2 other bits", 32'(irqOut), 0);
      wr(3'd1, 32'(1 << n)); settle();
      chk("R2 own bit", 32'(irqOut), 1);
      ackRead(v); chk("R4 single vec", v, n);
      settle();
      rd(3'd3, v); chk("R6 svc set", v, 32'(1 << n));
      chk("R6 irq drops", 32'(irqOut), 0);
      cleanup();
    end

    // R3 global enable gates output
    wr(3'd1, 32'hFF);
    wr(3'd0, cfgVal(0, 0, 0, 0));
    reqIn = 8'hFF; settle();
    chk("R3 disabled", 32'(irqOut), 0);
    reqIn = '0;
    wr(3'd0, cfgVal(1, 0, 0, 0)); settle();

    // R4 sweep all request patterns
    for (int p = 1; p < 256; p++) begin
      reqIn = 8'(p); settle();
      if (irqOut !== 1'b1) chk("R12 irq raised", 32'(irqOut), 1);
      ackRead(v); chk("R4 lowest wins", v, lowest(8'(p)));
      cleanup();
    end

    // R5 promotion sweep
    for (int k = 0; k < NS; k++) begin
      wr(3'd0, cfgVal(1, 1, k, 0));
      for (int p = 1; p < 256; p++) begin
        reqIn = 8'(p); settle();
        ackRead(v);
        chk("R5 promoted", v, p[k] ? k : lowest(8'(p)));
        cleanup();
      end
    end
    wr(3'd0, cfgVal(1, 0, 0, 0)); settle();

    // R6 nesting and blocking
    reqIn = 8'h28; settle();
    ackRead(v); chk("R6 first", v, 3);
    settle();
    chk("R6 blocked", 32'(irqOut), 0);
    reqIn = 8'h68; settle();
    chk("R6 lower blocked", 32'(irqOut), 0);
    reqIn = 8'h6A; settle();
    chk("R6 nested raise", 32'(irqOut), 1);
    ackRead(v); chk("R6 nested vec", v, 1);
    settle();
    rd(3'd3, v); chk("R6 both in svc", v, 32'h0A);
    chk("R6 irq low", 32'(irqOut), 0);

    // R7 write-one-to-clear
    wr(3'd3, 32'h0); settle();
    rd(3'd3, v); chk("R7 zero write", v, 32'h0A);
    wr(3'd3, 32'h02); settle();
    rd(3'd3, v); chk("R7 single clear", v, 32'h08);

    // R8 still-asserted source requests again
    chk("R8 rerequest", 32'(irqOut), 1);
    reqIn = 8'h68; settle();
    chk("R8 dropped", 32'(irqOut), 0);
    wr(3'd3, 32'h08); settle();
    chk("R8 rerequest2", 32'(irqOut), 1);
    ackRead(v); chk("R8 vec", v, 3);
    cleanup();

    // R9 error vector: withdrawn request
    reqIn = 8'h10; settle();
    chk("R9 raised", 32'(irqOut), 1);
    reqIn = '0; @(negedge clk); @(negedge clk);
    ackRead(v); chk("R9 withdrawn", v, ERR);
    settle();
    rd(3'd3, v); chk("R9 svc untouched", v, 0);
    // R9 error vector: masked in the race
    reqIn = 8'h10; settle();
    chk("R9 raised2", 32'(irqOut), 1);
    wr(3'd1, 32'hEF);
    ackRead(v); chk("R9 masked", v, ERR);
    settle();
    rd(3'd3, v); chk("R9 svc untouched2", v, 0);
    cleanup();

    // R10 level field and config readback
    wr(3'd0, cfgVal(1, 1, 6, 5)); @(negedge clk);
    chk("R10 level", 32'(irqLevel), 5);
    rd(3'd0, v); chk("R10 readback", v, cfgVal(1, 1, 6, 5));
    wr(3'd0, cfgVal(0, 0, 0, 2)); @(negedge clk);
    chk("R10 level2", 32'(irqLevel), 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule